// File: doc/BRIEF.md
# Exception Priority Resolver with Fault Escalation

This block looks at every exception request that is currently pending and decides which one the core should service next. Each exception is identified by its number, and the pending input is a vector with one bit per number. Three exceptions have fixed levels: Reset, NMI and Hard Fault. They rank above every programmable level. Every other implemented exception, including each external interrupt line, takes its level from a per-exception programmable field. A smaller value means a more urgent request.

The three configurable fault types (memory management, bus and usage) each have an enable bit. A fault of this kind is not dropped when it cannot be taken. It is converted into a Hard Fault request in two cases: when its enable bit is clear, and when the handler that is already running is at an equal or more urgent level. The block reports the chosen exception number and a valid flag. It also reports whether that choice would interrupt the handler that is running now. All three outputs are registered.

Top module: `exc_resolver`

## Requirements
- R1: Exception numbers 0, 7, 8, 9, 10 and 13 are not implemented. A request on any of them never produces a selection, and on its own it leaves `sel_valid_o` low.
- R2: The fixed levels are Reset (number 1) at -3, NMI (number 2) at -2 and Hard Fault (number 3) at -1. Each of them outranks any programmable level, including level 0.
- R3: Among pending requests, the one with the numerically smallest level is selected. Exception n takes its programmable level from `prio_i[n*3 +: 3]`, as an unsigned value from 0 to 7.
- R4: When two or more pending requests share the winning level, the one with the lower exception number is selected.
- R5: `fault_en_i` bit 0 enables memory management faults (number 4), bit 1 enables bus faults (number 5) and bit 2 enables usage faults (number 6). A pending fault whose bit is 0 is never selected as itself. It is presented as a Hard Fault (number 3) request instead.
- R6: A pending, enabled fault whose level is greater than or equal to the active level is never selected as itself. It is presented as a Hard Fault request. This applies only while `act_valid_i` is 1.
- R7: A pending, enabled fault whose level is strictly below the active level competes under its own number.
- R8: `preempt_o` is 1 only when the selected level is strictly below the active level. `act_lvl_i` is a 5-bit two's-complement value: -3, -2 and -1 stand for the fixed levels, and 0 to 7 for programmable levels. While `act_valid_i` is 0, every valid selection preempts.
- R9: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge. A synchronous reset drives `sel_valid_o`, `sel_num_o` and `preempt_o` to 0.
- R10: The external lines are numbered 16 to 16+N_EXT-1 (16 to 23 by default). Each competes at its own programmable level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pend_i | input | 16+N_EXT | Pending request per exception number |
| fault_en_i | input | 3 | Enable bits for memory management, bus and usage faults |
| prio_i | input | (16+N_EXT)*PRIO_W | Programmable level field per exception number |
| act_valid_i | input | 1 | A handler is currently active |
| act_lvl_i | input | PRIO_W+2 | Signed level of the active handler |
| sel_valid_o | output | 1 | A selection is available |
| sel_num_o | output | clog2(16+N_EXT) | Selected exception number |
| preempt_o | output | 1 | The selection outranks the active handler |

## Verification
Escalation and arbitration can fall in the same cycle. In that cycle a fault becomes a Hard Fault request while other requests are still competing. The bench provokes this in two ways: it pends a disabled or blocked fault alongside an external line at level 0, and it pends a disabled fault alongside an enabled one. It then checks that the escalated Hard Fault wins, and that the preempt flag follows the escalated level rather than the fault's own programmed level.

// File: rtl/exc_res_pkg.sv
package exc_res_pkg;

    localparam int EXC_RESET = 1;
    localparam int EXC_NMI   = 2;
    localparam int EXC_HARD  = 3;
    localparam int EXC_MEM   = 4;
    localparam int EXC_BUS   = 5;
    localparam int EXC_USAGE = 6;
    localparam int EXC_EXT0  = 16;
    localparam int N_FAULT   = 3;

    // True for numbers that carry a real exception.
    function automatic logic exc_implemented(input int n);
        return (n >= 1 && n <= 6) || n == 11 || n == 12 || n == 14 || n >= 15;
    endfunction

    // True for the three fixed-level exceptions.
    function automatic logic exc_fixed(input int n);
        return n >= EXC_RESET && n <= EXC_HARD;
    endfunction

endpackage

// File: rtl/exc_level_map.sv
module exc_level_map
    import exc_res_pkg::*;
#(
    parameter int NUM_EXC = 24,
    parameter int PRIO_W  = 3,
    localparam int LVL_W  = PRIO_W + 2
) (
    input  logic [NUM_EXC*PRIO_W-1:0] prio_i,
    output logic signed [LVL_W-1:0]   lvl_o [NUM_EXC]
);

    localparam logic signed [LVL_W-1:0] LVL_NONE = LVL_W'(1 << PRIO_W);

    for (genvar n = 0; n < NUM_EXC; n++) begin : g_lvl
        if (exc_fixed(n)) begin : g_fixed
            // Reset -3, NMI -2, Hard Fault -1
            assign lvl_o[n] = LVL_W'(n - 4);
        end else if (exc_implemented(n)) begin : g_prog
            assign lvl_o[n] = {2'b00, prio_i[n*PRIO_W +: PRIO_W]};
        end else begin : g_rsvd
            assign lvl_o[n] = LVL_NONE;
        end
    end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
    import exc_res_pkg::*;
#(
    parameter int NUM_EXC = 24,
    parameter int PRIO_W  = 3,
    localparam int LVL_W  = PRIO_W + 2
) (
    input  logic [NUM_EXC-1:0]        pend_i,
    input  logic [N_FAULT-1:0]        fault_en_i,
    input  logic signed [LVL_W-1:0]   lvl_i [NUM_EXC],
    input  logic                      act_valid_i,
    input  logic signed [LVL_W-1:0]   act_lvl_i,
    output logic [NUM_EXC-1:0]        pend_eff_o
);

    logic [N_FAULT-1:0] blocked;
    logic [N_FAULT-1:0] escalate;

    for (genvar f = 0; f < N_FAULT; f++) begin : g_fault
        assign blocked[f]  = act_valid_i && (lvl_i[EXC_MEM+f] >= act_lvl_i);
        assign escalate[f] = pend_i[EXC_MEM+f] && (!fault_en_i[f] || blocked[f]);
    end

    for (genvar n = 0; n < NUM_EXC; n++) begin : g_eff
        if (n == EXC_HARD) begin : g_hard
            assign pend_eff_o[n] = pend_i[n] || (|escalate);
        end else if (n >= EXC_MEM && n < EXC_MEM + N_FAULT) begin : g_flt
            assign pend_eff_o[n] = pend_i[n] && !escalate[n-EXC_MEM];
        end else if (exc_implemented(n)) begin : g_plain
            assign pend_eff_o[n] = pend_i[n];
        end else begin : g_rsvd
            assign pend_eff_o[n] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int NUM_EXC = 24,
    parameter int PRIO_W  = 3,
    localparam int LVL_W  = PRIO_W + 2,
    localparam int NUM_W  = $clog2(NUM_EXC)
) (
    input  logic [NUM_EXC-1:0]        pend_i,
    input  logic signed [LVL_W-1:0]   lvl_i [NUM_EXC],
    output logic                      valid_o,
    output logic [NUM_W-1:0]          num_o,
    output logic signed [LVL_W-1:0]   lvl_o
);

    localparam logic signed [LVL_W-1:0] LVL_NONE = LVL_W'(1 << PRIO_W);

    always_comb begin
        valid_o = 1'b0;
        num_o   = '0;
        lvl_o   = LVL_NONE;
        // Downward scan with <= leaves the lowest number on a tie.
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (pend_i[i] && (!valid_o || lvl_i[i] <= lvl_o)) begin
                valid_o = 1'b1;
                num_o   = NUM_W'(i);
                lvl_o   = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
    import exc_res_pkg::*;
#(
    parameter int N_EXT   = 8,
    parameter int PRIO_W  = 3,
    localparam int NUM_EXC = EXC_EXT0 + N_EXT,
    localparam int LVL_W   = PRIO_W + 2,
    localparam int NUM_W   = $clog2(NUM_EXC)
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_EXC-1:0]        pend_i,
    input  logic [N_FAULT-1:0]        fault_en_i,
    input  logic [NUM_EXC*PRIO_W-1:0] prio_i,
    input  logic                      act_valid_i,
    input  logic [LVL_W-1:0]          act_lvl_i,
    output logic                      sel_valid_o,
    output logic [NUM_W-1:0]          sel_num_o,
    output logic                      preempt_o
);

    localparam logic signed [LVL_W-1:0] LVL_IDLE = LVL_W'(1 << PRIO_W);

    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
        logic             preempt;
    } sel_t;

    logic signed [LVL_W-1:0] lvl      [NUM_EXC];
    logic [NUM_EXC-1:0]      pend_eff;
    logic                    pick_valid;
    logic [NUM_W-1:0]        pick_num;
    logic signed [LVL_W-1:0] pick_lvl;
    logic signed [LVL_W-1:0] cur_lvl;
    sel_t                    sel_d, sel_q;

    exc_level_map #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_map (
        .prio_i (prio_i),
        .lvl_o  (lvl)
    );

    exc_escalate #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_esc (
        .pend_i      (pend_i),
        .fault_en_i  (fault_en_i),
        .lvl_i       (lvl),
        .act_valid_i (act_valid_i),
        .act_lvl_i   ($signed(act_lvl_i)),
        .pend_eff_o  (pend_eff)
    );

    exc_pick #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_pick (
        .pend_i  (pend_eff),
        .lvl_i   (lvl),
        .valid_o (pick_valid),
        .num_o   (pick_num),
        .lvl_o   (pick_lvl)
    );

    always_comb begin
        cur_lvl       = act_valid_i ? $signed(act_lvl_i) : LVL_IDLE;
        sel_d.valid   = pick_valid;
        sel_d.num     = pick_num;
        sel_d.preempt = pick_valid && (pick_lvl < cur_lvl);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sel_q <= '0;
        else       sel_q <= sel_d;
    end

    assign sel_valid_o = sel_q.valid;
    assign sel_num_o   = sel_q.num;
    assign preempt_o   = sel_q.preempt;

endmodule

// File: rtl/exc_resolver_chk.sv
module exc_resolver_chk
    import exc_res_pkg::*;
#(
    parameter int N_EXT   = 8,
    parameter int PRIO_W  = 3,
    localparam int NUM_EXC = EXC_EXT0 + N_EXT,
    localparam int LVL_W   = PRIO_W + 2,
    localparam int NUM_W   = $clog2(NUM_EXC)
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic [NUM_EXC-1:0]        pend_i,
    input logic [N_FAULT-1:0]        fault_en_i,
    input logic [NUM_EXC*PRIO_W-1:0] prio_i,
    input logic                      act_valid_i,
    input logic [LVL_W-1:0]          act_lvl_i,
    input logic                      sel_valid_o,
    input logic [NUM_W-1:0]          sel_num_o,
    input logic                      preempt_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (!sel_valid_o && sel_num_o == '0 && !preempt_o)); // R9

    AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_valid_o |-> exc_implemented(int'(sel_num_o))); // R1

    AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        pend_i[EXC_RESET] |=> (sel_valid_o && sel_num_o == NUM_W'(EXC_RESET))); // R2

    AST_DISABLED_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_i[EXC_MEM] && !fault_en_i[0]) |=> !(sel_valid_o && sel_num_o == NUM_W'(EXC_MEM))); // R5

    AST_PREEMPT_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        preempt_o |-> sel_valid_o); // R8

    AST_IDLE_PREEMPTS: assert property (@(posedge clk_i) disable iff (rst_i)
        !act_valid_i |=> (preempt_o == sel_valid_o)); // R8

endmodule

bind exc_resolver exc_resolver_chk #(.N_EXT(N_EXT), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/exc_resolver_tb.sv
module exc_resolver_tb;

    localparam int NUM_EXC = 24;
    localparam int PRIO_W  = 3;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [NUM_EXC-1:0]        pend = '0;
    logic [2:0]                fen = '0;
    logic [NUM_EXC*PRIO_W-1:0] prio = '0;
    logic                      act = 1'b0;
    logic [4:0]                alvl = '0;
    logic                      sv;
    logic [4:0]                sn;
    logic                      sp;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    exc_resolver #(.N_EXT(8), .PRIO_W(PRIO_W)) u_dut (
        .clk_i(clk), .rst_i(rst), .pend_i(pend), .fault_en_i(fen), .prio_i(prio),
        .act_valid_i(act), .act_lvl_i(alvl),
        .sel_valid_o(sv), .sel_num_o(sn), .preempt_o(sp)
    );

    // Level set 0: every exception at 4. Set 1: mixed levels.
    function automatic logic [NUM_EXC*PRIO_W-1:0] prio_set(input logic s);
        logic [NUM_EXC*PRIO_W-1:0] p;
        for (int n = 0; n < NUM_EXC; n++) p[n*PRIO_W +: PRIO_W] = 3'd4;
        if (s) begin
            p[4*3 +: 3]  = 3'd6;  p[5*3 +: 3]  = 3'd1;  p[6*3 +: 3]  = 3'd3;
            p[11*3 +: 3] = 3'd2;  p[12*3 +: 3] = 3'd5;  p[14*3 +: 3] = 3'd7;
            p[15*3 +: 3] = 3'd5;  p[16*3 +: 3] = 3'd2;  p[17*3 +: 3] = 3'd0;
            p[18*3 +: 3] = 3'd0;  p[23*3 +: 3] = 3'd1;
        end
        return p;
    endfunction

    typedef struct packed {
        logic [23:0] pend;
        logic        pset;
        logic [2:0]  en;
        logic        act;
        logic [4:0]  lvl;
        logic        ev;
        logic [4:0]  en_num;
        logic        ep;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{24'h000000, 1'b0, 3'b111, 1'b0, 5'd0,     1'b0, 5'd0,  1'b0, 8'd1},  // R1 nothing pending
        '{24'h002781, 1'b0, 3'b111, 1'b0, 5'd0,     1'b0, 5'd0,  1'b0, 8'd1},  // R1 reserved only
        '{24'h01000E, 1'b0, 3'b111, 1'b0, 5'd0,     1'b1, 5'd1,  1'b1, 8'd2},  // R2 reset wins
        '{24'h02000C, 1'b1, 3'b111, 1'b0, 5'd0,     1'b1, 5'd2,  1'b1, 8'd2},  // R2 NMI over level 0
        '{24'h000808, 1'b1, 3'b111, 1'b0, 5'd0,     1'b1, 5'd3,  1'b1, 8'd2},  // R2 Hard Fault
        '{24'h01D000, 1'b1, 3'b111, 1'b0, 5'd0,     1'b1, 5'd16, 1'b1, 8'd3},  // R3 R10 lowest level
        '{24'h860000, 1'b1, 3'b111, 1'b0, 5'd0,     1'b1, 5'd17, 1'b1, 8'd4},  // R4 tie 17/18
        '{24'h108800, 1'b0, 3'b111, 1'b0, 5'd0,     1'b1, 5'd11, 1'b1, 8'd4},  // R4 tie all 4
        '{24'h000020, 1'b1, 3'b000, 1'b0, 5'd0,     1'b1, 5'd3,  1'b1, 8'd5},  // R5 bus disabled
        '{24'h020040, 1'b1, 3'b011, 1'b0, 5'd0,     1'b1, 5'd3,  1'b1, 8'd5},  // R5 usage disabled vs lvl0
        '{24'h000040, 1'b1, 3'b111, 1'b1, 5'd2,     1'b1, 5'd3,  1'b1, 8'd6},  // R6 blocked higher
        '{24'h000040, 1'b1, 3'b111, 1'b1, 5'd3,     1'b1, 5'd3,  1'b1, 8'd6},  // R6 blocked equal
        '{24'h000010, 1'b1, 3'b111, 1'b1, 5'd0,     1'b1, 5'd3,  1'b1, 8'd6},  // R6 mem lvl6 vs 0
        '{24'h000020, 1'b1, 3'b111, 1'b1, 5'd2,     1'b1, 5'd5,  1'b1, 8'd7},  // R7 bus taken
        '{24'h010000, 1'b1, 3'b111, 1'b1, 5'd2,     1'b1, 5'd16, 1'b0, 8'd8},  // R8 equal no preempt
        '{24'h008800, 1'b1, 3'b111, 1'b1, 5'd2,     1'b1, 5'd11, 1'b0, 8'd8},  // R8 equal svc
        '{24'h020000, 1'b1, 3'b111, 1'b1, 5'b11111, 1'b1, 5'd17, 1'b0, 8'd8},  // R8 under Hard Fault
        '{24'h000002, 1'b1, 3'b111, 1'b1, 5'b11110, 1'b1, 5'd1,  1'b1, 8'd8},  // R8 reset over NMI
        '{24'h000030, 1'b1, 3'b110, 1'b0, 5'd0,     1'b1, 5'd3,  1'b1, 8'd5}   // R5 mem disabled + bus
    };

    task automatic check(input logic ev, input logic [4:0] en, input logic ep, input int r);
        n_chk++;
        if (sv !== ev || (ev && sn !== en) || sp !== ep) begin
            n_bad++;
            $display("FAIL R%0d: got valid=%0b num=%0d preempt=%0b, expected valid=%0b num=%0d preempt=%0b",
                     r, sv, sn, sp, ev, en, ep);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, 5'd0, 1'b0, 9);      // R9 reset state
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            pend = VECS[v].pend; prio = prio_set(VECS[v].pset);
            fen = VECS[v].en; act = VECS[v].act; alvl = VECS[v].lvl;
            @(posedge clk); @(negedge clk);
            check(VECS[v].ev, VECS[v].en_num, VECS[v].ep, int'(VECS[v].req));
        end

        // R9: outputs hold until the next edge
        pend = 24'h800000; prio = prio_set(1'b0); fen = 3'b111; act = 1'b0;
        @(posedge clk); @(negedge clk);
        check(1'b1, 5'd23, 1'b1, 10);   // R10 last external line
        pend = 24'h000004;
        #2;
        check(1'b1, 5'd23, 1'b1, 9);    // R9 no combinational path
        @(posedge clk); @(negedge clk);
        check(1'b1, 5'd2, 1'b1, 9);     // R9 updated after edge

        // R9: synchronous reset clears a live selection
        pend = 24'h000002; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(1'b0, 5'd0, 1'b0, 9);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(1'b1, 5'd1, 1'b1, 2);     // R2 after reset release

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule